// File: doc/BRIEF.md
# Multi-channel prescaled PWM generator

This block is a bank of pulse-width-modulated outputs configured through a small byte-wide register port. Each channel owns a pair of configuration bytes that together hold a 4-bit frequency code F and a 10-bit duty value D. All channels share one enable byte. A channel's waveform always spans 1024 time quanta per period. The length of a quantum is set by the frequency code: a prescaler divides the input clock by 32 − F, so the ratio runs from 17 to 32. With a 9.6 MHz input clock this gives roughly 293 Hz to 551 Hz.

D is stored as the high count minus one. A running channel is therefore high for D+1 quanta at the start of every period, anywhere from one quantum to the whole period. A disabled channel holds its output low. Zero duty has no encoding of its own; software gets it by clearing the enable bit.

Configuration writes go into the register file at once. The running channel only takes them up at its next period boundary, so a period is never cut short. Setting an enable bit starts a fresh period with the output high.

Top module: `pwm_bank`

## Requirements
- R1: After synchronous reset every register reads zero, every channel is disabled and every `pwm_o` bit is low.
- R2: Channel n's low byte sits at 0x60+2n and its high byte at 0x61+2n. The enable byte sits at 0x66, with bit n enabling channel n. `reg_rdata` shows the register addressed on the previous clock edge. Any unmapped address reads 0x00.
- R3: High-byte bits [3:2] always read zero. Enable-byte bits at or above the channel count also read zero.
- R4: A running channel's period lasts exactly 1024 × (32 − F) clock cycles, where F is high-byte bits [7:4].
- R5: A running channel is high for (D+1) × (32 − F) cycles at the start of each period. D's bits [7:0] come from the low byte and bits [9:8] from high-byte bits [1:0].
- R6: If an enable bit is cleared on clock edge E, that channel's output is low from edge E+1 onward and stays low.
- R7: If an enable bit is set on clock edge E, that channel's output goes high at edge E+1 and begins a full new period.
- R8: Duty or frequency writes made during a period leave the current period unchanged. They apply from the next period onward.
- R9: With D = 1023 the output stays high continuously.
- R10: A channel's output depends only on its own registers and its own enable bit. A disabled channel stays low while others run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address for both write and read |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_rdata | output | 8 | Registered read data for the previous address |
| pwm_o | output | 3 | One PWM output per channel |

## Verification
The bench targets the extremes of the waveform. The smallest duty at the fastest prescale must give a single 17-cycle pulse, so an off-by-one on the stored duty would show as 0 or 34 cycles. Full duty must never drop low; a wrap compare that forgot the D+1 encoding would emit a one-quantum notch. A write in mid-period, changing both duty and frequency, must leave that period at exactly 17408 cycles; a design that applied settings at once would give a truncated or stretched period. Readback checks the masked reserved bits and the enable byte's upper bits, and confirms that unmapped addresses return zero rather than aliasing a channel register.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int PWM_FREQ_W = 4;
  localparam int PWM_DUTY_W = 10;
  localparam int PWM_DUTY_HI_W = PWM_DUTY_W - 8;

  typedef struct packed {
    logic [PWM_FREQ_W-1:0] freq;
    logic [PWM_DUTY_W-1:0] duty;
  } ch_cfg_t;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h60,
  parameter int EN_ADDR   = 'h66
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 wdata,
  input  logic                       we,
  output logic [7:0]                 rdata,
  output ch_cfg_t [NUM_CH-1:0]       cfg,
  output logic [NUM_CH-1:0]          en
);

  localparam logic [7:0] HI_MASK = 8'hF0 | 8'((1 << PWM_DUTY_HI_W) - 1);
  localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_ADDR);

  logic [7:0] lo_q [NUM_CH];
  logic [7:0] hi_q [NUM_CH];
  logic [7:0] rd_next;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_ADDR + 2 * g);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_ADDR + 2 * g + 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (we) begin
        if (addr == LO_A) lo_q[g] <= wdata;
        if (addr == HI_A) hi_q[g] <= wdata & HI_MASK;
      end
    end

    assign cfg[g].duty = {hi_q[g][PWM_DUTY_HI_W-1:0], lo_q[g]};
    assign cfg[g].freq = hi_q[g][7:4];
  end

  always_ff @(posedge clk) begin
    if (rst)                     en <= '0;
    else if (we && addr == EN_A) en <= wdata[NUM_CH-1:0];
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(BASE_ADDR + 2 * i))     rd_next = lo_q[i];
      if (addr == ADDR_W'(BASE_ADDR + 2 * i + 1)) rd_next = hi_q[i];
    end
    if (addr == EN_A) rd_next[NUM_CH-1:0] = en;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/pwm_quantum_tick.sv
module pwm_quantum_tick #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  localparam int CNT_W = CODE_W + 1;
  localparam logic [CNT_W-1:0] TOP = CNT_W'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = TOP - {1'b0, code};
  assign tick = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  ch_cfg_t cfg,
  output logic    pwm
);

  localparam logic [PWM_DUTY_W-1:0] Q_LAST = '1;

  logic                  running;
  logic [PWM_DUTY_W-1:0] q;
  logic [PWM_DUTY_W:0]   q_nx;
  ch_cfg_t               act;
  logic                  tick;

  assign q_nx = {1'b0, q} + 1'b1;

  pwm_quantum_tick #(.CODE_W(PWM_FREQ_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (!(en && running)),
    .code  (act.freq),
    .tick  (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      q       <= '0;
      act     <= '0;
      pwm     <= 1'b0;
    end else if (!en) begin
      running <= 1'b0;
      q       <= '0;
      pwm     <= 1'b0;
    end else if (!running) begin
      running <= 1'b1;
      q       <= '0;
      act     <= cfg;
      pwm     <= 1'b1;
    end else if (tick) begin
      if (q == Q_LAST) begin
        q   <= '0;
        act <= cfg;
        pwm <= 1'b1;
      end else begin
        q   <= q_nx[PWM_DUTY_W-1:0];
        pwm <= (q_nx <= {1'b0, act.duty});
      end
    end
  end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h60,
  parameter int EN_ADDR   = 'h66
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  output logic [NUM_CH-1:0] pwm_o
);

  ch_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]    en_q;

  pwm_regfile #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .EN_ADDR   (EN_ADDR)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .we    (reg_we),
    .rdata (reg_rdata),
    .cfg   (cfg),
    .en    (en_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel u_ch (
      .clk (clk),
      .rst (rst),
      .en  (en_q[g]),
      .cfg (cfg[g]),
      .pwm (pwm_o[g])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH    = 3,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h60,
  parameter int EN_ADDR   = 'h66
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] en_q
);

  localparam int TOP_A = BASE_ADDR + 2 * NUM_CH;

  logic in_pairs, unmapped, is_hi;
  assign in_pairs = (int'(reg_addr) >= BASE_ADDR) && (int'(reg_addr) < TOP_A);
  assign unmapped = !in_pairs && (int'(reg_addr) != EN_ADDR);
  assign is_hi    = in_pairs && (((int'(reg_addr) - BASE_ADDR) % 2) == 1);

  // R1: outputs and read data are quiet just after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwm_o == '0 && reg_rdata == 8'h00));

  // R2: unmapped addresses read zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> (reg_rdata == 8'h00));

  // R3: reserved high-byte bits read zero
  p_hi_mask_r3: assert property (@(posedge clk) disable iff (rst)
    is_hi |=> (reg_rdata[3:2] == 2'b00));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // R6: disabled channel is low one edge later
    p_disable_low_r6: assert property (@(posedge clk) disable iff (rst)
      !en_q[g] |=> !pwm_o[g]);
    // R7: enabling begins a period with the output high
    p_enable_high_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(en_q[g]) |=> pwm_o[g]);
  end

endmodule

bind pwm_bank pwm_bank_chk #(
  .NUM_CH    (NUM_CH),
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .EN_ADDR   (EN_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .pwm_o     (pwm_o),
  .en_q      (en_q)
);

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic [2:0] pwm_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_bank u0 (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .pwm_o     (pwm_o)
  );

  // {ch[63:60], F[59:56], D[55:40], expected high[39:20], expected period[19:0]}
  localparam logic [63:0] VEC [3] = '{
    {4'd0, 4'd15, 16'd0,   20'd17,   20'd17408},
    {4'd1, 4'd12, 16'd300, 20'd6020, 20'd20480},
    {4'd2, 4'd0,  16'd7,   20'd256,  20'd32768}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    int lo = 0;
    hi = 0;
    for (int i = 0; i < 40000 && !pwm_o[ch]; i++) @(negedge clk);
    while (pwm_o[ch] && hi < 40000) begin hi++; @(negedge clk); end
    while (!pwm_o[ch] && lo < 40000) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int v, hi, per, hi2, per2, lows;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pwm_o after reset", int'(pwm_o), 0);
    rd(8'h61, v); chk("R1 high byte after reset", v, 0);
    rd(8'h66, v); chk("R1 enable after reset", v, 0);

    // R2 / R3 register map and readback
    wr(8'h60, 8'hA5); rd(8'h60, v); chk("R2 ch0 low byte", v, 'hA5);
    wr(8'h63, 8'hFF); rd(8'h63, v); chk("R3 ch1 high byte mask", v, 'hF3);
    wr(8'h64, 8'h3C); rd(8'h64, v); chk("R2 ch2 low byte", v, 'h3C);
    rd(8'h60, v); chk("R2 ch0 low byte kept", v, 'hA5);
    rd(8'h67, v); chk("R2 unmapped above", v, 0);
    rd(8'h5F, v); chk("R2 unmapped below", v, 0);
    wr(8'h66, 8'hFF); rd(8'h66, v); chk("R3 enable upper bits", v, 'h07);
    wr(8'h66, 8'h00); rd(8'h66, v); chk("R2 enable cleared", v, 0);

    // R4 / R5 / R10 vector table
    foreach (VEC[k]) begin
      int ch, f, d;
      ch = int'(VEC[k][63:60]); f = int'(VEC[k][59:56]); d = int'(VEC[k][55:40]);
      wr(8'h66, 8'h00);
      wr(8'(8'h60 + 2 * ch), 8'(d));
      wr(8'(8'h61 + 2 * ch), 8'((f << 4) | (d >> 8)));
      wr(8'h66, 8'(1 << ch));
      measure(ch, hi, per);
      chk($sformatf("R5 high time vec%0d", k), hi, int'(VEC[k][39:20]));
      chk($sformatf("R4 period vec%0d", k), per, int'(VEC[k][19:0]));
      chk($sformatf("R10 others low vec%0d", k), int'(pwm_o & ~3'(1 << ch)), 0);
    end

    // R9 full duty on ch1, F=15
    wr(8'h66, 8'h00);
    wr(8'h62, 8'hFF); wr(8'h63, 8'hF3);
    wr(8'h66, 8'h02);
    @(negedge clk);
    lows = 0;
    for (int i = 0; i < 17460; i++) begin
      if (!pwm_o[1]) lows++;
      @(negedge clk);
    end
    chk("R9 low samples at full duty", lows, 0);

    // R6 disable
    wr(8'h66, 8'h00);
    @(negedge clk);
    chk("R6 low after disable", int'(pwm_o[1]), 0);
    lows = 0;
    for (int i = 0; i < 50; i++) begin
      if (pwm_o[1]) lows++;
      @(negedge clk);
    end
    chk("R6 stays low", lows, 0);

    // R7 enable starts high
    wr(8'h66, 8'h02);
    chk("R7 not yet high", int'(pwm_o[1]), 0);
    @(negedge clk);
    chk("R7 high one edge after enable", int'(pwm_o[1]), 1);

    // R8 mid-period update of duty and frequency on ch0
    wr(8'h66, 8'h00);
    wr(8'h60, 8'h00); wr(8'h61, 8'hF0);
    wr(8'h66, 8'h01);
    fork
      measure(0, hi, per);
      begin
        repeat (100) @(negedge clk);
        wr(8'h60, 8'd100);
        wr(8'h61, 8'hE0);
      end
    join
    chk("R8 current period high unchanged", hi, 17);
    chk("R8 current period length unchanged", per, 17408);
    measure(0, hi2, per2);
    chk("R8 new high time", hi2, 1818);
    chk("R8 new period", per2, 18432);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule